// File: doc/BRIEF.md
# Power-of-Two Clock Output Divider

This block takes a fast clock and produces one output clock at the input rate divided by 1, 2, 4 or 8. A two-bit code picks the ratio. The code is not monotonic: the all-ones value means no division. For every ratio the output spends half of its period high and half low. In the undivided setting the input clock passes through a gate to the output.

An active-high enable turns the output on or off without cutting a pulse short. Both the enable and the ratio code are sampled only in the last input cycle of an output period. The output is always low in that cycle, so every pulse starts and ends at full width. A synchronous reset clears the divide chain and holds the output low.

A typical use is the final stage of a synthesized clock source. A frequency loop sets the fast clock, and this divider widens the output range by powers of two. With a loop step of 2 MHz, the output steps are 2 MHz, 1 MHz, 500 kHz and 250 kHz for ratios 1, 2, 4 and 8.

Top module: `pow2_clk_div`

## Requirements
- R1: The ratio code gives the output period in input cycles: 2'b00 gives 2, 2'b01 gives 4, 2'b10 gives 8 and 2'b11 gives 1.
- R2: For ratios 2, 4 and 8, an enabled output is high for the first half of the input cycles of each period and low for the second half. Each period starts at a rising edge of the input clock.
- R3: While the sampled enable is low, the output stays low through both clock phases.
- R4: The enable input is sampled only at the input clock edge that ends an output period. A change at any other time has no effect on the output until that edge.
- R5: The ratio code is sampled only at the input clock edge that ends an output period. The next period runs entirely at the new ratio.
- R6: At every clock edge where the synchronous reset is high, the divide chain is cleared, the sampled enable is cleared and the ratio code is loaded. The output is low for the whole of the next cycle.
- R7: At ratio 1, the output follows the input clock while enabled and stays low while disabled. The enable is held by a latch that is open only while the clock is low, so the high phase following an edge already shows the enable sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ratio_i | input | 2 | Ratio code (00:/2, 01:/4, 10:/8, 11:/1) |
| en_i | input | 1 | Output enable, active high |
| clk_o | output | 1 | Divided and gated clock output |

## Verification
The assertions check several properties on every clock edge:
- the count wraps only at the end of a period and otherwise steps by one;
- the ratio code and the sampled enable hold still away from a period boundary;
- the divided output rises only at a period start and is low in the last cycle of a period.

Other behaviour can only be shown by the bench's scenarios, which sample the output in both clock phases against an independent model:
- the actual period length for each code;
- the exact phase placement of the gated pass-through at ratio 1;
- the low output after a reset in the middle of a period;
- the clean handover when the ratio or the enable changes in the middle of a period.

// File: rtl/pow2_div_pkg.sv
package pow2_div_pkg;

  localparam int MAX_LOG2 = 3;
  localparam int CNT_W    = MAX_LOG2;
  localparam int DIV_W    = MAX_LOG2 + 1;

  typedef enum logic [1:0] {
    RATIO_D2 = 2'b00,
    RATIO_D4 = 2'b01,
    RATIO_D8 = 2'b10,
    RATIO_D1 = 2'b11
  } ratio_e;

  // Division ratio in input cycles per output period.
  function automatic logic [DIV_W-1:0] ratio_divisor(input logic [1:0] code);
    case (ratio_e'(code))
      RATIO_D2: ratio_divisor = DIV_W'(2);
      RATIO_D4: ratio_divisor = DIV_W'(4);
      RATIO_D8: ratio_divisor = DIV_W'(8);
      default:  ratio_divisor = DIV_W'(1);
    endcase
  endfunction

  // Count value held in the final cycle of a period.
  function automatic logic [CNT_W-1:0] last_count(input logic [1:0] code);
    logic [DIV_W-1:0] d;
    d = ratio_divisor(code) - DIV_W'(1);
    last_count = d[CNT_W-1:0];
  endfunction

  // Number of high cycles per period for the divided path (0 at ratio 1).
  function automatic logic [CNT_W-1:0] high_count(input logic [1:0] code);
    logic [DIV_W-1:0] d;
    d = ratio_divisor(code) >> 1;
    high_count = d[CNT_W-1:0];
  endfunction

endpackage

// File: rtl/pow2_div_ratio.sv
module pow2_div_ratio
  import pow2_div_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [1:0]    ratio_i,
  input  logic          boundary_i,
  output logic [CW-1:0] last_cnt_o,
  output logic [CW-1:0] half_next_o,
  output logic          is_div1_o
);

  logic [1:0] code_q;
  logic       take_new;

  assign take_new = rst_i | boundary_i;

  always_ff @(posedge clk_i) begin
    if (take_new) code_q <= ratio_i;
  end

  assign last_cnt_o  = CW'(last_count(code_q));
  assign half_next_o = take_new ? CW'(high_count(ratio_i)) : CW'(high_count(code_q));
  assign is_div1_o   = (ratio_e'(code_q) == RATIO_D1);

  // R5: the active ratio only moves at a period boundary
  p_code_hold_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    !boundary_i |=> $stable(code_q));

endmodule

// File: rtl/pow2_div_count.sv
module pow2_div_count
  import pow2_div_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [CW-1:0] last_cnt_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cnt_next_o,
  output logic          boundary_o
);

  logic [CW-1:0] cnt_q;

  assign boundary_o = (cnt_q == last_cnt_i);
  assign cnt_next_o = (rst_i || boundary_o) ? '0 : cnt_q + CW'(1);

  always_ff @(posedge clk_i) begin
    cnt_q <= cnt_next_o;
  end

  assign cnt_o = cnt_q;

  // R1: a period ends by returning to zero
  p_wrap_zero_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    boundary_o |=> (cnt_q == '0));

  // R1: inside a period the count steps by one
  p_step_one_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    !boundary_o |=> (cnt_q == CW'($past(cnt_q) + CW'(1))));

endmodule

// File: rtl/pow2_div_gate.sv
module pow2_div_gate
  import pow2_div_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          en_i,
  input  logic          boundary_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] cnt_next_i,
  input  logic [CW-1:0] half_next_i,
  input  logic          is_div1_i,
  output logic          clk_o
);

  logic en_act_q;
  logic en_next;
  logic en_lat;
  logic div_q;
  logic div_next;

  // Enable is taken only where the output is low: end of a period.
  assign en_next = rst_i ? 1'b0 : (boundary_i ? en_i : en_act_q);

  assign div_next = en_next && (cnt_next_i < half_next_i);

  always_ff @(posedge clk_i) begin
    en_act_q <= en_next;
    div_q    <= div_next;
  end

  // Open only while the clock is low, so the gate cannot chop a high phase.
  always_latch begin
    if (!clk_i) en_lat = en_next;
  end

  assign clk_o = is_div1_i ? (clk_i & en_lat) : div_q;

  // R4: the sampled enable holds between period boundaries
  p_en_hold_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    !boundary_i |=> $stable(en_act_q));

  // R2: a divided pulse begins only at the start of a period
  p_rise_start_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(div_q) |-> (cnt_i == '0));

  // R2: the divided output is low in the last cycle of a period
  p_low_at_end_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (boundary_i && !is_div1_i) |-> !div_q);

endmodule

// File: rtl/pow2_clk_div.sv
module pow2_clk_div
  import pow2_div_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic [1:0] ratio_i,
  input  logic       en_i,
  output logic       clk_o
);

  logic [CNT_W-1:0] last_cnt;
  logic [CNT_W-1:0] half_next;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_next;
  logic             boundary;
  logic             is_div1;

  pow2_div_ratio #(.CW(CNT_W)) u_ratio (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .ratio_i     (ratio_i),
    .boundary_i  (boundary),
    .last_cnt_o  (last_cnt),
    .half_next_o (half_next),
    .is_div1_o   (is_div1)
  );

  pow2_div_count #(.CW(CNT_W)) u_count (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .last_cnt_i (last_cnt),
    .cnt_o      (cnt),
    .cnt_next_o (cnt_next),
    .boundary_o (boundary)
  );

  pow2_div_gate #(.CW(CNT_W)) u_gate (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .en_i        (en_i),
    .boundary_i  (boundary),
    .cnt_i       (cnt),
    .cnt_next_i  (cnt_next),
    .half_next_i (half_next),
    .is_div1_i   (is_div1),
    .clk_o       (clk_o)
  );

endmodule

// File: tb/pow2_clk_div_tb_top.sv
module pow2_clk_div_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] ratio = 2'b00;
  logic       en = 1'b1;
  logic       clk_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pow2_clk_div dut_i (
    .clk_i   (clk),
    .rst_i   (rst),
    .ratio_i (ratio),
    .en_i    (en),
    .clk_o   (clk_o)
  );

  typedef struct {
    logic  hi;
    logic  lo;
    string tag;
  } exp_t;

  exp_t sb_q[$];

  // Ratio as restated from R1: all-ones is 1, otherwise 2 shifted by the code.
  function automatic int code_to_div(input logic [1:0] c);
    return (c == 2'b11) ? 1 : (2 << c);
  endfunction

  int    m_cnt = 0;
  int    m_div = 2;
  bit    m_en  = 0;
  string m_tag = "R6";

  // Reference model: pushes the expected value of both phases after each edge.
  always @(posedge clk) begin
    exp_t e;
    if (rst) begin
      m_cnt = 0;
      m_en  = 0;
      m_div = code_to_div(ratio);
      m_tag = "R6";
    end else if (m_cnt == m_div - 1) begin
      int nd;
      nd = code_to_div(ratio);
      if (nd != m_div) m_tag = "R5";
      else if (en != m_en) m_tag = "R4";
      else m_tag = (nd == 1) ? "R7" : "R2";
      m_div = nd;
      m_en  = en;
      m_cnt = 0;
    end else begin
      m_cnt++;
    end
    if (m_div == 1) begin
      e.hi = m_en;
      e.lo = 1'b0;
    end else begin
      e.hi = m_en && (m_cnt < m_div / 2);
      e.lo = e.hi;
    end
    e.tag = (!m_en && m_tag != "R6") ? "R3" : m_tag;
    sb_q.push_back(e);
  end

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // Monitor: compares the high phase and the low phase of every input cycle.
  initial begin
    forever begin
      exp_t e;
      @(posedge clk);
      #2;
      if (sb_q.size() != 0) begin
        e = sb_q.pop_front();
        check(e.tag, clk_o, e.hi, "high phase");
        #5;
        check(e.tag, clk_o, e.lo, "low phase");
      end
    end
  end

  int rises = 0;
  always @(posedge clk_o) rises++;

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drive(input logic [1:0] r, input logic e);
    @(negedge clk);
    ratio = r;
    en    = e;
  endtask

  // R1: count output rising edges over 64 input cycles at a settled ratio.
  task automatic measure_r1(input logic [1:0] r);
    drive(r, 1'b1);
    cycles(20);
    rises = 0;
    cycles(64);
    checks++;
    if (rises != 64 / code_to_div(r)) begin
      errors++;
      $display("FAIL R1 code %b rising edges actual=%0d expected=%0d", r, rises, 64 / code_to_div(r));
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cycles(4);
    // R6: output low while in reset
    checks++;
    if (clk_o !== 1'b0) begin
      errors++;
      $display("FAIL R6 output in reset actual=%b expected=0", clk_o);
    end
    rst = 1'b0;
    cycles(30);

    measure_r1(2'b00);
    measure_r1(2'b01);
    measure_r1(2'b10);
    measure_r1(2'b11);

    // R3 / R4: enable dropped and raised at odd points inside periods
    drive(2'b10, 1'b1);
    cycles(19);
    drive(2'b10, 1'b0);
    cycles(3);
    drive(2'b10, 1'b1);
    cycles(1);
    drive(2'b10, 1'b0);
    cycles(24);
    drive(2'b10, 1'b1);
    cycles(13);

    // R5: ratio changes mid-period in every direction, including through /1
    drive(2'b01, 1'b1);
    cycles(5);
    drive(2'b11, 1'b1);
    cycles(7);
    drive(2'b00, 1'b1);
    cycles(3);
    drive(2'b10, 1'b1);
    cycles(2);
    drive(2'b11, 1'b1);
    cycles(11);

    // R7: enable toggles at ratio 1
    drive(2'b11, 1'b0);
    cycles(4);
    drive(2'b11, 1'b1);
    cycles(4);

    // Mixed pattern of codes and enables
    for (int i = 0; i < 120; i++) begin
      drive(2'(i * 7 + (i >> 3)), ((i % 5) != 0));
      cycles(i % 6);
    end

    // R6: reset in the middle of a long period
    drive(2'b10, 1'b1);
    cycles(10);
    @(negedge clk);
    rst = 1'b1;
    cycles(2);
    rst = 1'b0;
    cycles(40);

    finish_run();
  end

endmodule